// File: doc/BRIEF.md
# CAN Interframe and Overload Sequencer

This block takes over the bus after the frame engine reports that a frame, or an error delimiter, has ended. It steps through the intermission field and, for a node that is error-passive and transmitted the last message, through the suspend-transmission field. It then settles in bus idle. While it does this it watches the sampled bus level and the receiver's not-ready request, and it sends overload frames when one of three triggers occurs. Each overload frame is a dominant flag followed by a recessive delimiter.

The block advances one bit time per sample strobe. The frame engine marks the last bit of end-of-frame with `eof_end` and the last bit of an error delimiter with `errdel_last`. The block drives `tx_bit` with the level to transmit during the next bit time, where 1 is recessive and 0 is dominant. It pulses `sof` when a dominant bit is to be taken as start of frame. It pulses `err_inc` when the error counters must be incremented.

The block allows at most two overload frames between two starts of frame. Further triggers are ignored until the next start of frame clears the count.

Top module: `can_ifs_seq`

## Requirements
- R1: After synchronous reset the block is in bus idle: `tx_bit`=1, `bus_idle`=1, `ovl_active`=0, `sof`=0, `err_inc`=0.
- R2: Outputs change only in the clock cycle that follows a cycle with `bit_stb` high. A bus level seen without a strobe has no effect.
- R3: After the last end-of-frame bit, intermission lasts three recessive bits and the block then enters bus idle. In bus idle a sampled dominant bit (`rx_bit`=0) pulses `sof` for one clock and clears `bus_idle`.
- R4: A dominant bit sampled on the third intermission bit pulses `sof` and starts no overload frame.
- R5: A dominant bit sampled on the first or second intermission bit starts an overload flag in the next bit time. While an overload frame runs, `ovl_active` is 1.
- R6: The overload flag is exactly six bit times of `tx_bit`=0.
- R7: After the flag, `tx_bit` is 1 and the block waits for the first recessive sample, however many dominant bits follow. That sample plus seven further recessive bits form the delimiter. `ovl_active` falls after the last of them, and intermission follows.
- R8: A dominant bit sampled on the eighth bit of an overload delimiter, or with `errdel_last` high, pulses `err_inc` and starts an overload flag in the next bit time. A recessive sample there starts intermission.
- R9: When `rx_not_ready` is high on the bit that ends a frame or a delimiter, the overload flag replaces the first intermission bit. At any later intermission bit the request has no effect.
- R10: At most two overload frames are started between two `sof` pulses. A further trigger is ignored: `tx_bit` stays 1 and `ovl_active` stays 0. An `sof` pulse restores the allowance.
- R11: If `err_passive` and `was_tx` are both 1, eight recessive suspend bits follow intermission before bus idle. A dominant bit during suspend pulses `sof`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_stb | input | 1 | One-clock pulse at each bit sample point |
| rx_bit | input | 1 | Sampled bus level, 1 = recessive |
| eof_end | input | 1 | Current sample is the last end-of-frame bit |
| errdel_last | input | 1 | Current sample is the eighth error-delimiter bit |
| rx_not_ready | input | 1 | Receiver requests a delay of the next frame |
| err_passive | input | 1 | Node is error-passive |
| was_tx | input | 1 | Node transmitted the previous message |
| tx_bit | output | 1 | Level to transmit in the next bit time |
| sof | output | 1 | One-clock start-of-frame pulse |
| bus_idle | output | 1 | Block is in bus idle |
| ovl_active | output | 1 | Overload flag or delimiter in progress |
| err_inc | output | 1 | One-clock error-counter increment pulse |

## Verification
The assertions are checked on every cycle and cover four properties:
- outputs stay frozen between strobes;
- every overload flag lasts exactly six bit times;
- no more than two flags start between two starts of frame;
- `sof` and `err_inc` each follow a dominant sample.

Only the bench scenarios can show the rest: which intermission bit turns a dominant level into an overload rather than a start of frame; the delimiter resynchronising after extra dominant bits; the not-ready request being honoured only at the first intermission bit; and the suspend field lengthening the gap for an error-passive transmitter.

// File: rtl/ifs_pkg.sv
// Shared types for the interframe / overload sequencer.
package ifs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FRAME,
        ST_INTERM,
        ST_SUSPEND,
        ST_OFLAG,
        ST_OWAIT,
        ST_ODELIM
    } ifs_state_e;
endpackage

// File: rtl/ifs_field_cnt.sv
// Bit counter within the current field.
// Assumes: clr is high when the field changes; the count saturates at all ones.
module ifs_field_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stb,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    // Count strobes; restart at zero whenever a new field begins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (stb) begin
            if (clr)
                cnt <= '0;
            else if (cnt != {W{1'b1}})
                cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ifs_ovl_limit.sv
// Counts overload frames started since the last start of frame and grants new ones.
// Assumes: start and clear are never high on the same strobe.
module ifs_ovl_limit #(
    parameter int MAX_OVL = 2,
    parameter int W       = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic start,
    input  logic clear,
    output logic ok
);
    localparam logic [W-1:0] MAX_V = W'(MAX_OVL);

    logic [W-1:0] used;

    // Track overload frames already used; a start of frame frees the allowance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            used <= '0;
        else if (stb) begin
            if (clear)
                used <= '0;
            else if (start && used < MAX_V)
                used <= used + 1'b1;
        end
    end

    // A new overload frame is allowed while the allowance is not used up.
    always_comb ok = (used < MAX_V);
endmodule

// File: rtl/ifs_decide.sv
// Next-state decision for one sampled bit.
// Assumes: cnt is the 0-based bit index within the current field.
module ifs_decide
    import ifs_pkg::*;
#(
    parameter int INTERM_BITS = 3,
    parameter int SUSP_BITS   = 8,
    parameter int FLAG_BITS   = 6,
    parameter int DELIM_BITS  = 8,
    parameter int CNT_W       = 4
) (
    input  ifs_state_e       state,
    input  logic [CNT_W-1:0] cnt,
    input  logic             rx_bit,
    input  logic             eof_end,
    input  logic             errdel_last,
    input  logic             rx_not_ready,
    input  logic             err_passive,
    input  logic             was_tx,
    input  logic             ovl_ok,
    output ifs_state_e       nxt,
    output logic             sof_set,
    output logic             einc_set,
    output logic             ovl_start
);
    localparam logic [CNT_W-1:0] INT_LAST  = CNT_W'(INTERM_BITS - 1);
    localparam logic [CNT_W-1:0] SUSP_LAST = CNT_W'(SUSP_BITS - 1);
    localparam logic [CNT_W-1:0] FLAG_LAST = CNT_W'(FLAG_BITS - 1);
    // The first delimiter bit is consumed while leaving the wait state.
    localparam logic [CNT_W-1:0] DEL_LAST  = CNT_W'(DELIM_BITS - 2);

    logic field_end;   // a frame or a delimiter ends on this sample
    logic dlm_end;     // that end is a delimiter's eighth bit
    logic dom;

    // Decide where the sampled bit takes the sequencer.
    always_comb begin
        nxt       = state;
        sof_set   = 1'b0;
        einc_set  = 1'b0;
        ovl_start = 1'b0;
        field_end = 1'b0;
        dlm_end   = 1'b0;
        dom       = !rx_bit;
        unique case (state)
            ST_IDLE: begin
                if (dom) begin
                    sof_set = 1'b1;
                    nxt     = ST_FRAME;
                end
            end
            ST_FRAME: begin
                field_end = eof_end || errdel_last;
                dlm_end   = errdel_last;
            end
            ST_INTERM: begin
                if (dom) begin
                    if (cnt == INT_LAST) begin
                        sof_set = 1'b1;
                        nxt     = ST_FRAME;
                    end else if (ovl_ok) begin
                        ovl_start = 1'b1;
                        nxt       = ST_OFLAG;
                    end
                end else if (cnt == INT_LAST) begin
                    nxt = (err_passive && was_tx) ? ST_SUSPEND : ST_IDLE;
                end
            end
            ST_SUSPEND: begin
                if (dom) begin
                    sof_set = 1'b1;
                    nxt     = ST_FRAME;
                end else if (cnt == SUSP_LAST) begin
                    nxt = ST_IDLE;
                end
            end
            ST_OFLAG: begin
                if (cnt == FLAG_LAST)
                    nxt = ST_OWAIT;
            end
            ST_OWAIT: begin
                if (rx_bit)
                    nxt = ST_ODELIM;
            end
            ST_ODELIM: begin
                field_end = (cnt == DEL_LAST);
                dlm_end   = field_end;
            end
            default: nxt = ST_IDLE;
        endcase
        // Common handling at the end of a frame or a delimiter.
        if (field_end) begin
            if (dlm_end && dom)
                einc_set = 1'b1;
            if (ovl_ok && (rx_not_ready || (dlm_end && dom))) begin
                ovl_start = 1'b1;
                nxt       = ST_OFLAG;
            end else begin
                nxt = ST_INTERM;
            end
        end
    end
endmodule

// File: rtl/can_ifs_seq.sv
// Interframe / overload sequencer: top level.
// Assumes: bit_stb pulses one clock per bit time; frame engine markers are valid with it.
module can_ifs_seq
    import ifs_pkg::*;
#(
    parameter int INTERM_BITS = 3,
    parameter int SUSP_BITS   = 8,
    parameter int FLAG_BITS   = 6,
    parameter int DELIM_BITS  = 8,
    parameter int MAX_OVL     = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_stb,
    input  logic rx_bit,
    input  logic eof_end,
    input  logic errdel_last,
    input  logic rx_not_ready,
    input  logic err_passive,
    input  logic was_tx,
    output logic tx_bit,
    output logic sof,
    output logic bus_idle,
    output logic ovl_active,
    output logic err_inc
);
    localparam int LONG12 = (SUSP_BITS > DELIM_BITS) ? SUSP_BITS : DELIM_BITS;
    localparam int LONG34 = (FLAG_BITS > INTERM_BITS) ? FLAG_BITS : INTERM_BITS;
    localparam int LONGEST = (LONG12 > LONG34) ? LONG12 : LONG34;
    localparam int CNT_W = $clog2(LONGEST + 1);
    localparam int OVL_W = $clog2(MAX_OVL + 1);

    ifs_state_e       state, nxt;
    logic [CNT_W-1:0] cnt;
    logic             sof_set, einc_set, ovl_start, ovl_ok;

    ifs_field_cnt #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (bit_stb),
        .clr   (nxt != state),
        .cnt   (cnt)
    );

    ifs_ovl_limit #(.MAX_OVL(MAX_OVL), .W(OVL_W)) u_lim (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (bit_stb),
        .start (ovl_start),
        .clear (sof_set),
        .ok    (ovl_ok)
    );

    ifs_decide #(
        .INTERM_BITS (INTERM_BITS),
        .SUSP_BITS   (SUSP_BITS),
        .FLAG_BITS   (FLAG_BITS),
        .DELIM_BITS  (DELIM_BITS),
        .CNT_W       (CNT_W)
    ) u_dec (
        .state        (state),
        .cnt          (cnt),
        .rx_bit       (rx_bit),
        .eof_end      (eof_end),
        .errdel_last  (errdel_last),
        .rx_not_ready (rx_not_ready),
        .err_passive  (err_passive),
        .was_tx       (was_tx),
        .ovl_ok       (ovl_ok),
        .nxt          (nxt),
        .sof_set      (sof_set),
        .einc_set     (einc_set),
        .ovl_start    (ovl_start)
    );

    // Advance the field state on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else if (bit_stb)
            state <= nxt;
    end

    // One-clock event pulses aligned with the state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sof     <= 1'b0;
            err_inc <= 1'b0;
        end else begin
            sof     <= bit_stb && sof_set;
            err_inc <= bit_stb && einc_set;
        end
    end

    // Status and transmit level decoded from the state.
    always_comb begin
        tx_bit     = (state != ST_OFLAG);
        bus_idle   = (state == ST_IDLE);
        ovl_active = (state == ST_OFLAG) || (state == ST_OWAIT) || (state == ST_ODELIM);
    end
endmodule

// File: rtl/ifs_seq_chk.sv
// Checker for can_ifs_seq, attached by bind; observes ports only.
module ifs_seq_chk #(
    parameter int FLAG_BITS = 6,
    parameter int MAX_OVL   = 2
) (
    input logic clk,
    input logic rst_n,
    input logic bit_stb,
    input logic rx_bit,
    input logic tx_bit,
    input logic sof,
    input logic bus_idle,
    input logic ovl_active,
    input logic err_inc
);
    logic       tx_q;
    logic [7:0] flag_len;
    logic [7:0] flag_starts;

    // Track flag length in bit times and flags started since the last start of frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q        <= 1'b1;
            flag_len    <= '0;
            flag_starts <= '0;
        end else begin
            tx_q <= tx_bit;
            if (tx_bit)
                flag_len <= '0;
            else if (bit_stb)
                flag_len <= flag_len + 1'b1;
            if (sof)
                flag_starts <= '0;
            else if (tx_q && !tx_bit)
                flag_starts <= flag_starts + 1'b1;
        end
    end

    p_hold_between_strobes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_stb |=> ($stable(tx_bit) && $stable(bus_idle) && $stable(ovl_active)));

    p_sof_after_dominant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sof |-> ($past(bit_stb) && !$past(rx_bit) && !bus_idle && !ovl_active));

    p_flag_six_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_bit && !tx_q) |-> (flag_len == 8'(FLAG_BITS)));

    p_flag_in_overload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_bit |-> ovl_active);

    p_einc_after_dominant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_inc |-> ($past(bit_stb) && !$past(rx_bit)));

    p_ovl_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flag_starts <= 8'(MAX_OVL));
endmodule

bind can_ifs_seq ifs_seq_chk #(.FLAG_BITS(FLAG_BITS), .MAX_OVL(MAX_OVL)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_stb    (bit_stb),
    .rx_bit     (rx_bit),
    .tx_bit     (tx_bit),
    .sof        (sof),
    .bus_idle   (bus_idle),
    .ovl_active (ovl_active),
    .err_inc    (err_inc)
);

// File: tb/tb_can_ifs_seq.sv
module tb_can_ifs_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_stb = 1'b0, rx_bit = 1'b1, eof_end = 1'b0, errdel_last = 1'b0;
    logic rx_not_ready = 1'b0, err_passive = 1'b0, was_tx = 1'b0;
    logic tx_bit, sof, bus_idle, ovl_active, err_inc;
    logic got_sof, got_einc;
    int   n_chk = 0, n_fail = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    can_ifs_seq dut (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .rx_bit(rx_bit),
        .eof_end(eof_end), .errdel_last(errdel_last), .rx_not_ready(rx_not_ready),
        .err_passive(err_passive), .was_tx(was_tx), .tx_bit(tx_bit), .sof(sof),
        .bus_idle(bus_idle), .ovl_active(ovl_active), .err_inc(err_inc)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // One bit time: strobe with the given bus level and markers, capture pulses.
    task automatic step(input logic rx, input logic eofe, input logic edl);
        @(negedge clk);
        rx_bit = rx; eof_end = eofe; errdel_last = edl; bit_stb = 1'b1;
        @(negedge clk);
        bit_stb = 1'b0; eof_end = 1'b0; errdel_last = 1'b0;
        got_sof = sof; got_einc = err_inc;
        @(negedge clk);
    endtask

    // Flag (bus dominant), then eight recessive delimiter bits.
    task automatic run_overload(input int extra);
        for (int k = 0; k < 6; k++) begin
            chk("R6 flag dominant", tx_bit, 0);
            step(1'b0, 1'b0, 1'b0);
        end
        chk("R6 flag ends", tx_bit, 1);
        for (int e = 0; e < extra; e++) begin
            step(1'b0, 1'b0, 1'b0);
            chk("R7 wait for recessive", ovl_active, 1);
        end
        for (int d = 0; d < 8; d++) begin
            step(1'b1, 1'b0, 1'b0);
            chk("R7 delimiter length", ovl_active, (d < 7) ? 1 : 0);
        end
    endtask

    // Two recessive intermission bits, then a dominant start of frame.
    task automatic interm_to_sof();
        step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        chk("R4 sof on third intermission bit", got_sof, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 tx", tx_bit, 1);
        chk("R1 idle", bus_idle, 1);
        chk("R1 ovl", ovl_active, 0);
        chk("R1 sof", sof, 0);
        chk("R1 einc", err_inc, 0);

        // R2: dominant level without strobe changes nothing
        rx_bit = 1'b0;
        repeat (5) @(negedge clk);
        chk("R2 no strobe", bus_idle, 1);
        chk("R2 no sof", sof, 0);

        // R3: dominant in bus idle is start of frame
        step(1'b0, 1'b0, 1'b0);
        chk("R3 sof from idle", got_sof, 1);
        chk("R3 leaves idle", bus_idle, 0);

        // R3 / R11 sweep: plain and suspended interframe gaps
        was_tx = 1'b1;
        for (int s = 0; s < 2; s++) begin
            int total;
            err_passive = s[0];
            total = 3 + (s == 1 ? 8 : 0);
            step(1'b1, 1'b1, 1'b0);
            for (int i = 0; i < total; i++) begin
                step(1'b1, 1'b0, 1'b0);
                chk(s == 1 ? "R11 suspend gap" : "R3 intermission gap", bus_idle, (i == total - 1) ? 1 : 0);
            end
            step(1'b0, 1'b0, 1'b0);
            chk("R3 sof after gap", got_sof, 1);
        end
        // R11: dominant during suspend is start of frame
        err_passive = 1'b1;
        step(1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        chk("R11 sof in suspend", got_sof, 1);
        err_passive = 1'b0;
        was_tx = 1'b0;

        // R4 / R5 sweep over the dominant position within intermission
        for (int p = 0; p < 3; p++) begin
            step(1'b1, 1'b1, 1'b0);
            for (int i = 0; i < p; i++) step(1'b1, 1'b0, 1'b0);
            step(1'b0, 1'b0, 1'b0);
            if (p == 2) begin
                chk("R4 sof", got_sof, 1);
                chk("R4 no overload", ovl_active, 0);
            end else begin
                chk("R5 overload starts", ovl_active, 1);
                chk("R5 no sof", got_sof, 0);
                run_overload(p);
                interm_to_sof();
            end
        end

        // R8 / R10: chained overloads and the cap
        step(1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        chk("R5 first overload", ovl_active, 1);
        for (int k = 0; k < 6; k++) step(1'b0, 1'b0, 1'b0);
        for (int d = 0; d < 7; d++) step(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        chk("R8 einc on delimiter end", got_einc, 1);
        chk("R8 second flag", tx_bit, 0);
        for (int k = 0; k < 6; k++) step(1'b0, 1'b0, 1'b0);
        for (int d = 0; d < 7; d++) step(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        chk("R8 einc even when capped", got_einc, 1);
        chk("R10 third overload ignored tx", tx_bit, 1);
        chk("R10 third overload ignored ovl", ovl_active, 0);
        step(1'b0, 1'b0, 1'b0);
        chk("R10 intermission trigger ignored", ovl_active, 0);
        step(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        chk("R4 sof after cap", got_sof, 1);
        step(1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        chk("R10 allowance restored by sof", ovl_active, 1);
        run_overload(0);
        interm_to_sof();

        // R9: not-ready honoured only at the first intermission bit
        rx_not_ready = 1'b1;
        step(1'b1, 1'b1, 1'b0);
        chk("R9 flag replaces first intermission bit", tx_bit, 0);
        chk("R9 overload active", ovl_active, 1);
        rx_not_ready = 1'b0;
        run_overload(0);
        step(1'b1, 1'b0, 1'b0);
        rx_not_ready = 1'b1;
        step(1'b1, 1'b0, 1'b0);
        chk("R9 late request ignored", ovl_active, 0);
        step(1'b1, 1'b0, 1'b0);
        chk("R9 reaches idle", bus_idle, 1);
        rx_not_ready = 1'b0;
        step(1'b0, 1'b0, 1'b0);

        // R8: error delimiter end, recessive then dominant
        step(1'b1, 1'b0, 1'b1);
        chk("R8 recessive starts intermission", ovl_active, 0);
        chk("R8 no einc", got_einc, 0);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0);
        chk("R8 idle after intermission", bus_idle, 1);
        step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b1);
        chk("R8 einc on error delimiter", got_einc, 1);
        chk("R8 overload after error delimiter", ovl_active, 1);
        run_overload(2);
        interm_to_sof();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule